// File: doc/BRIEF.md
# One-time-programmable fuse word controller

This block sits on a 32-bit register bus and looks after a small array of 32-bit one-time-programmable fuse words. Software picks a word index in the control register. It then starts either a read, whose result lands in a read-data register, or a programming pass, which can only turn fuse bits from 0 to 1. A programming pass runs only when a 16-bit unlock key has first been placed in the upper half of the control register. A separate reload command copies every fuse word into a bank of shadow registers that software can read directly.

Each operation lasts a number of clock cycles taken from a software-loaded timing register: a relax period, then a read or program strobe period, then a second relax period. While an operation runs, a busy flag is visible in the control register. Misuse raises a sticky error flag. Misuse covers a wrong key, an index outside the array, and a command issued while busy or while the error flag is already set. Software clears the error flag through a clear alias of the control register.

Top module: `fuse_ctrl`

## Requirements
- R1: After reset the control register (offset 0x00) reads 0, the read-data register (0x40) reads 0, and the timing register (0x10) reads 0x0003100A, which is strobe-read 3, relax 1 and strobe-program 10.
- R2: Control register layout: word index in [6:0], busy in bit 8, error in bit 9, reload in bit 10, unlock field in [31:16]. A write to 0x00 replaces the index and unlock fields. A 1 written through 0x04 sets the matching index or unlock bit, and a 1 written through 0x08 clears it. A direct write never changes busy or error.
- R3: Writing the program-data register (0x20) while the unlock field holds 0x3E77 and the index is in range ORs the data into the addressed word. Busy reads 1 for exactly 2*relax + strobe-program cycles.
- R4: When a programming pass completes, the unlock field returns to 0.
- R5: Writing 0x20 with any other unlock value sets error, leaves busy at 0, and leaves the word unchanged.
- R6: Writing 1 to bit 0 of 0x30 with an in-range index holds busy for exactly 2*relax + strobe-read cycles. After that, 0x40 holds the addressed word.
- R7: A read of an index at or above the number of words sets error, loads 0xBADABADA into 0x40, and does not raise busy.
- R8: A read, program or reload command issued while busy or error is 1 starts nothing and sets error.
- R9: Error stays set through other writes. Only a 1 in bit 9 written to 0x08 clears it.
- R10: A 1 in bit 10 written to 0x00 or 0x04 starts a reload. Reload and busy read 1 for 2*relax + strobe-read cycles. Then both clear, and every shadow register equals its fuse word.
- R11: Shadow word n reads at 0x400 + 0x10*n. Shadow registers change only on a reload, never on programming. Offsets with nonzero low nibble, and indices at or above the number of words, read 0.
- R12: The timing register takes strobe-program in [11:0], relax in [15:12] and strobe-read in [21:16]. It reads back those fields, and later operations take their lengths from it.
- R13: A programming write with the correct key but an out-of-range index sets error, starts nothing, and keeps the unlock field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW (12) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The bench keeps the default eight-word array. Indices 8 through 127 are therefore out of range yet still encodable in the index field, which exercises the error-read and refused-program paths and the zero reads of shadow offsets past the array. The default timing counts keep operations at 12 and 5 cycles, so the bench can count exact busy windows. A reprogrammed timing register with zero relax shows the lengths follow software.

// File: rtl/fuse_ctrl.sv
module fuse_ctrl #(
  parameter int WORDS     = 8,
  parameter int AW        = 12,
  parameter int DEF_RELAX = 1,
  parameter int DEF_SREAD = 3,
  parameter int DEF_SPROG = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata
);
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [15:0] KEY = 16'h3E77;
  localparam logic [31:0] BAD = 32'hBADABADA;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_READ = 2'd1, OP_PROG = 2'd2, OP_LOAD = 2'd3;

  logic [6:0]  addr_q;
  logic [15:0] unlock_q;
  logic        err_q;
  logic [15:0] cnt_q;
  logic [1:0]  op_q;
  logic [IW-1:0] op_addr_q;
  logic [31:0] op_data_q;
  logic [11:0] t_sprog;
  logic [3:0]  t_relax;
  logic [5:0]  t_sread;
  logic [31:0] rd_q;
  logic [WORDS-1:0][31:0] fuse_q;
  logic [WORDS-1:0][31:0] shadow_q;

  wire busy = (cnt_q != 16'd0);
  wire done = (cnt_q == 16'd1);

  wire w_ctrl = bus_wr && (bus_addr == AW'('h00));
  wire w_set  = bus_wr && (bus_addr == AW'('h04));
  wire w_clr  = bus_wr && (bus_addr == AW'('h08));
  wire w_tim  = bus_wr && (bus_addr == AW'('h10));
  wire w_pd   = bus_wr && (bus_addr == AW'('h20));
  wire w_rc   = bus_wr && (bus_addr == AW'('h30));

  wire cmd_load = (w_ctrl || w_set) && bus_wdata[10];
  wire cmd_read = w_rc && bus_wdata[0];
  wire cmd_prog = w_pd;
  wire blocked  = busy || err_q;
  wire in_range = ({25'b0, addr_q} < 32'(WORDS));

  wire start_read = cmd_read && !blocked && in_range;
  wire start_prog = cmd_prog && !blocked && (unlock_q == KEY) && in_range;
  wire start_load = cmd_load && !blocked;
  wire bad_read   = cmd_read && !blocked && !in_range;
  wire err_set    = ((cmd_load || cmd_read || cmd_prog) && blocked) ||
                    (cmd_prog && !blocked && !start_prog) || bad_read;

  wire [15:0] relax2   = {11'b0, t_relax, 1'b0};
  wire [15:0] rd_raw   = relax2 + {10'b0, t_sread};
  wire [15:0] pg_raw   = relax2 + {4'b0, t_sprog};
  wire [15:0] rd_len   = (rd_raw == 16'd0) ? 16'd1 : rd_raw;
  wire [15:0] pg_len   = (pg_raw == 16'd0) ? 16'd1 : pg_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      unlock_q  <= '0;
      err_q     <= 1'b0;
      cnt_q     <= '0;
      op_q      <= OP_IDLE;
      op_addr_q <= '0;
      op_data_q <= '0;
      t_sprog   <= 12'(DEF_SPROG);
      t_relax   <= 4'(DEF_RELAX);
      t_sread   <= 6'(DEF_SREAD);
      rd_q      <= '0;
      fuse_q    <= '0;
      shadow_q  <= '0;
    end else begin
      if (busy) cnt_q <= cnt_q - 16'd1;
      if (done) begin
        case (op_q)
          OP_READ: rd_q <= fuse_q[op_addr_q];
          OP_PROG: begin
            fuse_q[op_addr_q] <= fuse_q[op_addr_q] | op_data_q;
            unlock_q <= '0;
          end
          OP_LOAD: shadow_q <= fuse_q;
          default: ;
        endcase
        op_q <= OP_IDLE;
      end

      if (w_ctrl) begin
        addr_q   <= bus_wdata[6:0];
        unlock_q <= bus_wdata[31:16];
      end else if (w_set) begin
        addr_q   <= addr_q | bus_wdata[6:0];
        unlock_q <= unlock_q | bus_wdata[31:16];
      end else if (w_clr) begin
        addr_q   <= addr_q & ~bus_wdata[6:0];
        unlock_q <= unlock_q & ~bus_wdata[31:16];
      end

      if (w_tim) begin
        t_sprog <= bus_wdata[11:0];
        t_relax <= bus_wdata[15:12];
        t_sread <= bus_wdata[21:16];
      end

      if (w_clr && bus_wdata[9]) err_q <= 1'b0;
      if (err_set) err_q <= 1'b1;

      if (bad_read) rd_q <= BAD;

      if (start_read || start_prog || start_load) begin
        op_addr_q <= addr_q[IW-1:0];
        op_data_q <= bus_wdata;
        cnt_q     <= start_prog ? pg_len : rd_len;
        op_q      <= start_prog ? OP_PROG : (start_read ? OP_READ : OP_LOAD);
      end
    end
  end

  wire [31:0] ctrl_rd = {unlock_q, 5'b0, (op_q == OP_LOAD), err_q, busy, 1'b0, addr_q};

  wire [AW-1:0] sh_off  = bus_addr - AW'('h400);
  wire [AW-1:0] sh_widx = sh_off >> 4;
  wire [IW-1:0] sh_idx  = sh_widx[IW-1:0];
  wire sh_hit = (bus_addr >= AW'('h400)) && (sh_off[3:0] == 4'd0) &&
                (32'(sh_widx) < 32'(WORDS));

  always_comb begin
    case (bus_addr)
      AW'('h00), AW'('h04), AW'('h08): bus_rdata = ctrl_rd;
      AW'('h10): bus_rdata = {10'b0, t_sread, t_relax, t_sprog};
      AW'('h40): bus_rdata = rd_q;
      default:   bus_rdata = sh_hit ? shadow_q[sh_idx] : 32'h0;
    endcase
  end
endmodule

// File: rtl/fuse_ctrl_chk.sv
module fuse_ctrl_chk #(
  parameter int WORDS = 8,
  parameter int AW    = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic [AW-1:0]          bus_addr,
  input logic [31:0]            bus_wdata,
  input logic                   busy,
  input logic                   err_q,
  input logic [15:0]            unlock_q,
  input logic [1:0]             op_q,
  input logic [WORDS-1:0][31:0] fuse_q,
  input logic [WORDS-1:0][31:0] shadow_q
);
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    a_r3_fuse_only_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(fuse_q[i]) & ~fuse_q[i]) == 32'h0));
  end

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !(bus_wr && bus_addr == AW'('h08) && bus_wdata[9]) |=> err_q);

  a_r8_busy_cmd_errs: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && busy && (bus_addr == AW'('h20) || (bus_addr == AW'('h30) && bus_wdata[0]))
    |=> err_q);

  a_r5_wrong_key: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AW'('h20) && !busy && !err_q && unlock_q != 16'h3E77
    |=> err_q && !busy);

  a_r10_reload_copies: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && $past(op_q) == 2'd3 |-> shadow_q == fuse_q);

  a_r4_unlock_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && $past(op_q) == 2'd2 && !$past(bus_wr && bus_addr <= AW'('h08))
    |-> unlock_q == 16'h0);
endmodule

bind fuse_ctrl fuse_ctrl_chk #(.WORDS(WORDS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .busy(busy), .err_q(err_q), .unlock_q(unlock_q),
  .op_q(op_q), .fuse_q(fuse_q), .shadow_q(shadow_q)
);

// File: tb/fuse_ctrl_bench.sv
`timescale 1ns/1ps
module fuse_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  fuse_ctrl u_fuse_ctrl (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic busy_len(output int n);
    logic [31:0] v;
    n = 0;
    for (int k = 0; k < 5000; k++) begin
      peek(12'h000, v);
      if (!v[8]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rd_word(input logic [6:0] idx, output logic [31:0] v, output int n);
    wr(12'h000, {25'b0, idx});
    wr(12'h030, 32'h1);
    busy_len(n);
    peek(12'h040, v);
  endtask

  task automatic prog_word(input logic [6:0] idx, input logic [31:0] d, output int n);
    wr(12'h000, {16'h3E77, 9'b0, idx});
    wr(12'h020, d);
    busy_len(n);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    peek(12'h000, v); chk("R1 ctrl after reset", v, 32'h0);
    peek(12'h010, v); chk("R1 timing default", v, 32'h0003_100A);
    peek(12'h040, v); chk("R1 read data", v, 32'h0);
  endtask

  task automatic t_alias;
    logic [31:0] v;
    wr(12'h000, 32'h5);          peek(12'h000, v); chk("R2 direct write", v, 32'h5);
    wr(12'h004, 32'h2);          peek(12'h000, v); chk("R2 set alias", v, 32'h7);
    wr(12'h008, 32'h1);          peek(12'h000, v); chk("R2 clear alias", v, 32'h6);
    wr(12'h004, 32'h3E77_0000);  peek(12'h000, v); chk("R2 set unlock", v, 32'h3E77_0006);
    wr(12'h008, 32'hFFFF_0000);  peek(12'h000, v); chk("R2 clear unlock", v, 32'h6);
    wr(12'h000, 32'h0000_0300);  peek(12'h000, v); chk("R2 busy/error not writable", v, 32'h0);
  endtask

  task automatic t_prog_read;
    logic [31:0] v; int n;
    prog_word(7'd3, 32'h0000_00F0, n);
    chk("R3 program busy cycles", n, 12);
    peek(12'h000, v); chk("R4 unlock cleared", v, 32'h3);
    rd_word(7'd3, v, n);
    chk("R6 read busy cycles", n, 5);
    chk("R6 read data", v, 32'h0000_00F0);
    prog_word(7'd3, 32'h0F00_0001, n);
    rd_word(7'd3, v, n);
    chk("R3 program ORs bits", v, 32'h0F00_00F1);
  endtask

  task automatic t_wrong_key;
    logic [31:0] v; int n;
    wr(12'h000, 32'h1234_0003);
    wr(12'h020, 32'hFFFF_FFFF);
    peek(12'h000, v); chk("R5 wrong key sets error, no busy", v, 32'h1234_0203);
    wr(12'h000, 32'h0000_0003);
    peek(12'h000, v); chk("R9 error survives direct write", v, 32'h0000_0203);
    wr(12'h008, 32'h0000_0100);
    peek(12'h000, v); chk("R9 error survives other clear bits", v, 32'h0000_0203);
    wr(12'h008, 32'h0000_0200);
    peek(12'h000, v); chk("R9 error cleared", v, 32'h3);
    rd_word(7'd3, v, n);
    chk("R5 word unchanged", v, 32'h0F00_00F1);
  endtask

  task automatic t_range;
    logic [31:0] v;
    wr(12'h000, 32'h9);
    wr(12'h030, 32'h1);
    peek(12'h000, v); chk("R7 bad read error, no busy", v, 32'h209);
    peek(12'h040, v); chk("R7 bad read data", v, 32'hBADA_BADA);
    wr(12'h008, 32'h200);
    wr(12'h000, 32'h3E77_0009);
    wr(12'h020, 32'h1);
    peek(12'h000, v); chk("R13 out-of-range program refused", v, 32'h3E77_0209);
    wr(12'h000, 32'h0);
    wr(12'h008, 32'h200);
  endtask

  task automatic t_blocked;
    logic [31:0] v; int n;
    wr(12'h000, 32'h3E77_0002);
    wr(12'h020, 32'h5);
    wr(12'h030, 32'h1);
    busy_len(n);
    peek(12'h000, v); chk("R8 command while busy sets error", v, 32'h0000_0202);
    wr(12'h000, 32'h3E77_0002);
    wr(12'h020, 32'h80);
    peek(12'h000, v); chk("R8 program while error ignored", v, 32'h3E77_0202);
    wr(12'h008, 32'h200);
    rd_word(7'd2, v, n);
    chk("R8 blocked program had no effect", v, 32'h5);
  endtask

  task automatic t_shadow;
    logic [31:0] v; int n;
    peek(12'h430, v); chk("R11 shadow stale before reload", v, 32'h0);
    wr(12'h004, 32'h400);
    peek(12'h000, v); chk("R10 reload and busy visible", v, 32'h502);
    busy_len(n);
    chk("R10 reload busy cycles", n, 5);
    peek(12'h000, v); chk("R10 reload bit cleared", v, 32'h002);
    peek(12'h430, v); chk("R10 shadow word 3", v, 32'h0F00_00F1);
    peek(12'h420, v); chk("R10 shadow word 2", v, 32'h5);
    peek(12'h400, v); chk("R10 shadow word 0", v, 32'h0);
    peek(12'h480, v); chk("R11 shadow beyond array", v, 32'h0);
    peek(12'h434, v); chk("R11 unaligned shadow offset", v, 32'h0);
    prog_word(7'd0, 32'h1, n);
    peek(12'h400, v); chk("R11 programming leaves shadow", v, 32'h0);
    wr(12'h000, 32'h400);
    busy_len(n);
    peek(12'h400, v); chk("R10 reload via direct write", v, 32'h1);
  endtask

  task automatic t_timing;
    logic [31:0] v; int n;
    wr(12'h010, 32'h0002_0004);
    peek(12'h010, v); chk("R12 timing readback", v, 32'h0002_0004);
    prog_word(7'd1, 32'h100, n);
    chk("R12 program length from timing", n, 4);
    rd_word(7'd1, v, n);
    chk("R12 read length from timing", n, 2);
    chk("R12 data with new timing", v, 32'h100);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #100_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alias();
    t_prog_read();
    t_wrong_key();
    t_range();
    t_blocked();
    t_shadow();
    t_timing();
    summary();
  end
endmodule